// File: doc/BRIEF.md
# Low-Speed NRZI Packet Serializer

This block drives a short packet onto a low-speed USB-style differential pair at a fixed eleven clocks per line symbol. A caller hands over a byte count through a ready/valid start port, and the block then pulls the payload bytes one at a time from a byte stream. A sync byte is placed in front of the payload by the block itself. Every bit goes out LSB first, NRZI-coded, with a stuffed toggle inserted after every run of six ones. The packet closes with a two-bit-time single-ended zero, one cycle of idle J, and then the drivers let go of the lines.

A separate request input sends a bare handshake (sync plus an ACK or NAK PID) with no payload fetch. The block also keeps the device address. Software-side logic writes a pending address at any time, and the block moves it into the active address only when a data packet reaches its end-of-packet. A handshake never does this, so a new address takes effect only once the reply carrying it has left the wire.

Top module: `lsx_pkt_tx`

## Requirements
- R1: The requested count includes the sync byte and is clamped to 2..12 (below 2 gives 2, above 12 gives 12). A data packet fetches exactly count-1 bytes, one per `data_ready`/`data_valid` beat.
- R2: The first eight line symbols are the sync byte 0x80 sent LSB first, which on the wire is K J K J K J K K starting from J.
- R3: After a packet is accepted, one cycle drives J (dp=0, dm=1) with `oe` low. The next cycle raises `oe` together with the first symbol, and every symbol lasts exactly 11 clocks.
- R4: The line is NRZI-coded. A 0 bit toggles between J (dp=0, dm=1) and K (dp=1, dm=0), and a 1 bit holds the level. Bytes go out LSB first, and dp and dm are never both high.
- R5: After six consecutive 1 bits, one extra toggle symbol is inserted that consumes no data bit. This also applies when the run spans a byte boundary or ends on the final bit before end-of-packet.
- R6: End-of-packet is dp=dm=0 with `oe` high for 22 clocks. This is followed by one cycle of J with `oe` high, after which `oe`, dp and dm are all low.
- R7: `hs_req` while idle sends only sync plus one PID: 0xD2 if `hs_nak`=0, 0x5A if `hs_nak`=1. It fetches no stream byte, and it wins over `start_valid` in the same cycle (`start_ready` is low while `hs_req` is high).
- R8: `addr_wr` stores a pending address. In the first end-of-packet cycle of a data packet only, a pending address becomes `dev_addr`. A write landing on that same edge stays pending, while the older pending value is the one committed.
- R9: `busy` is high from the cycle after acceptance until release. `done` is a one-cycle pulse in the release cycle. While busy, `start_ready` is low and `hs_req` is ignored.
- R10: After reset, the lines are released (dp=dm=oe=0), `busy`=`done`=0, `start_ready`=1 and `dev_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request a data packet |
| start_ready | output | 1 | Data packet request accepted this cycle when high with start_valid |
| start_len | input | LEN_W | Byte count including sync |
| data_valid | input | 1 | Payload byte present; if low when a byte is needed, the packet closes early |
| data_ready | output | 1 | Payload byte taken this cycle |
| data_byte | input | 8 | Payload byte |
| hs_req | input | 1 | Send handshake packet |
| hs_nak | input | 1 | Handshake type: 0 ACK, 1 NAK |
| addr_wr | input | 1 | Write pending device address |
| addr_in | input | ADDR_W | Pending address value |
| dev_addr | output | ADDR_W | Active device address |
| dp | output | 1 | Positive line level |
| dm | output | 1 | Negative line level |
| oe | output | 1 | Line drive enable |
| busy | output | 1 | Packet in progress |
| done | output | 1 | Release pulse |

## Verification
The address commit at the start of end-of-packet and an incoming pending-address write can fall on the same clock edge. The bench models the symbol count of each packet, including stuffed symbols. From that count it drives `addr_wr` so that it is sampled on exactly the edge that enters SE0. It then reads `dev_addr` in the first SE0 cycle and expects the older pending value. A following data packet must commit the colliding write. Handshake and data requests presented together, and requests arriving mid-packet, are also judged at the wire against the modelled waveform.

// File: rtl/lsx_tx_pkg.sv
package lsx_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SEND,
    ST_EOP,
    ST_JIDLE
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;
endpackage

// File: rtl/lsx_tx_timer.sv
// Symbol and end-of-packet timing counter.
module lsx_tx_timer #(
  parameter int CLKS_PER_BIT = 11,
  parameter int EOP_BITS     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_mode,
  output logic bit_end,
  output logic eop_end
);
  localparam int EOP_CLKS = CLKS_PER_BIT * EOP_BITS;
  localparam int CW       = $clog2(EOP_CLKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign bit_end = (cnt_q == CW'(CLKS_PER_BIT - 1));
  assign eop_end = (cnt_q == CW'(EOP_CLKS - 1));
  assign cnt_en  = clr | en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      if (bit_mode && bit_end) cnt_d = '0;
      else                     cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lsx_tx_stuffer.sv
// Bit shifter, NRZI level keeper and stuffing insertion.
module lsx_tx_stuffer
  import lsx_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       step,
  input  logic       have_next,
  input  logic [7:0] next_byte,
  output logic       line_j,
  output logic       want_byte,
  output logic       finished
);
  localparam int OW = $clog2(STUFF_RUN + 1);

  logic [7:0]    shreg_q, shreg_d;
  logic [2:0]    idx_q, idx_d;
  logic [OW-1:0] ones_q, ones_d;
  logic          lvl_q, lvl_d;
  logic          tail_q, tail_d;
  logic          stuff_now;
  logic          reg_en;

  assign stuff_now = (ones_q == OW'(STUFF_RUN));
  assign want_byte = step && !stuff_now && !tail_q && (idx_q == 3'd7);
  assign finished  = tail_q && !stuff_now;
  assign line_j    = lvl_q;
  assign reg_en    = init | step;

  always_comb begin
    shreg_d = shreg_q;
    idx_d   = idx_q;
    ones_d  = ones_q;
    lvl_d   = lvl_q;
    tail_d  = tail_q;
    if (init) begin
      shreg_d = SYNC_BYTE;
      idx_d   = '0;
      ones_d  = '0;
      lvl_d   = 1'b1;
      tail_d  = 1'b0;
    end else if (step) begin
      if (stuff_now) begin
        lvl_d  = ~lvl_q;
        ones_d = '0;
      end else if (!tail_q) begin
        if (shreg_q[0]) begin
          ones_d = ones_q + OW'(1);
        end else begin
          lvl_d  = ~lvl_q;
          ones_d = '0;
        end
        if (idx_q == 3'd7) begin
          if (have_next) begin
            shreg_d = next_byte;
            idx_d   = '0;
          end else begin
            tail_d = 1'b1;
          end
        end else begin
          shreg_d = {1'b0, shreg_q[7:1]};
          idx_d   = idx_q + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      idx_q   <= '0;
      ones_q  <= '0;
      lvl_q   <= 1'b1;
      tail_q  <= 1'b0;
    end else if (reg_en) begin
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      ones_q  <= ones_d;
      lvl_q   <= lvl_d;
      tail_q  <= tail_d;
    end
  end
endmodule

// File: rtl/lsx_tx_addr.sv
// Pending and active device address.
module lsx_tx_addr #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              commit,
  output logic [ADDR_W-1:0] dev_addr
);
  logic [ADDR_W-1:0] pend_q, pend_d, cur_q, cur_d;
  logic              pv_q, pv_d;

  always_comb begin
    pend_d = pend_q;
    pv_d   = pv_q;
    cur_d  = cur_q;
    if (commit && pv_q) begin
      cur_d = pend_q;
      pv_d  = 1'b0;
    end
    if (wr) begin
      pend_d = wr_addr;
      pv_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pv_q   <= 1'b0;
      cur_q  <= '0;
    end else begin
      pend_q <= pend_d;
      pv_q   <= pv_d;
      cur_q  <= cur_d;
    end
  end

  assign dev_addr = cur_q;
endmodule

// File: rtl/lsx_pkt_tx.sv
module lsx_pkt_tx
  import lsx_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 11,
  parameter int EOP_BITS     = 2,
  parameter int STUFF_RUN    = 6,
  parameter int MIN_BYTES    = 2,
  parameter int MAX_BYTES    = 12,
  parameter int LEN_W        = 4,
  parameter int ADDR_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic [7:0]        data_byte,
  input  logic              hs_req,
  input  logic              hs_nak,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dp,
  output logic              dm,
  output logic              oe,
  output logic              busy,
  output logic              done
);
  tx_state_e        state_q, state_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [LEN_W-1:0] len_eff;
  logic             is_hs_q, is_hs_d;
  logic [7:0]       pid_q, pid_d;
  logic             done_q, done_d;

  logic idle, take_hs, take_pkt, step, end_pkt;
  logic have_next, load_byte, commit;
  logic bit_end, eop_end, line_j, want_byte, finished;
  logic tmr_clr, tmr_en, tmr_bit;
  logic [7:0] next_byte;

  assign idle        = (state_q == ST_IDLE);
  assign start_ready = idle && !hs_req;
  assign take_hs     = idle && hs_req;
  assign take_pkt    = idle && start_valid && !hs_req;
  assign step        = (state_q == ST_ARM) || ((state_q == ST_SEND) && bit_end);
  assign end_pkt     = (state_q == ST_SEND) && bit_end && finished;
  assign have_next   = (left_q != '0) && (is_hs_q || data_valid);
  assign next_byte   = is_hs_q ? pid_q : data_byte;
  assign data_ready  = want_byte && !is_hs_q && (left_q != '0);
  assign load_byte   = want_byte && have_next;
  assign commit      = end_pkt && !is_hs_q;
  assign tmr_clr     = (state_q == ST_ARM) || end_pkt;
  assign tmr_en      = (state_q == ST_SEND) || (state_q == ST_EOP);
  assign tmr_bit     = (state_q == ST_SEND);

  always_comb begin
    if (start_len < LEN_W'(MIN_BYTES))      len_eff = LEN_W'(MIN_BYTES);
    else if (start_len > LEN_W'(MAX_BYTES)) len_eff = LEN_W'(MAX_BYTES);
    else                                    len_eff = start_len;
  end

  lsx_tx_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .EOP_BITS    (EOP_BITS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .en      (tmr_en),
    .bit_mode(tmr_bit),
    .bit_end (bit_end),
    .eop_end (eop_end)
  );

  lsx_tx_stuffer #(
    .STUFF_RUN(STUFF_RUN)
  ) u_stuff (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (take_hs | take_pkt),
    .step     (step),
    .have_next(have_next),
    .next_byte(next_byte),
    .line_j   (line_j),
    .want_byte(want_byte),
    .finished (finished)
  );

  lsx_tx_addr #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (addr_wr),
    .wr_addr (addr_in),
    .commit  (commit),
    .dev_addr(dev_addr)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    is_hs_d = is_hs_q;
    pid_d   = pid_q;
    done_d  = (state_q == ST_JIDLE);
    unique case (state_q)
      ST_IDLE: begin
        if (take_hs) begin
          state_d = ST_ARM;
          left_d  = LEN_W'(1);
          is_hs_d = 1'b1;
          pid_d   = hs_nak ? PID_NAK : PID_ACK;
        end else if (take_pkt) begin
          state_d = ST_ARM;
          left_d  = len_eff - LEN_W'(1);
          is_hs_d = 1'b0;
        end
      end
      ST_ARM:   state_d = ST_SEND;
      ST_SEND: begin
        if (end_pkt) state_d = ST_EOP;
        if (load_byte) left_d = left_q - LEN_W'(1);
      end
      ST_EOP:   if (eop_end) state_d = ST_JIDLE;
      ST_JIDLE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      is_hs_q <= 1'b0;
      pid_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      is_hs_q <= is_hs_d;
      pid_q   <= pid_d;
      done_q  <= done_d;
    end
  end

  // line decode
  always_comb begin
    dp = 1'b0;
    dm = 1'b0;
    oe = 1'b0;
    unique case (state_q)
      ST_ARM:   dm = 1'b1;
      ST_SEND: begin
        oe = 1'b1;
        dp = ~line_j;
        dm = line_j;
      end
      ST_EOP:   oe = 1'b1;
      ST_JIDLE: begin
        oe = 1'b1;
        dm = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = !idle;
  assign done = done_q;
endmodule

// File: rtl/lsx_tx_chk.sv
module lsx_tx_chk #(
  parameter int CLKS_PER_BIT = 11,
  parameter int EOP_BITS     = 2,
  parameter int ADDR_W       = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dp,
  input logic              dm,
  input logic              oe,
  input logic              busy,
  input logic              done,
  input logic              data_ready,
  input logic [ADDR_W-1:0] dev_addr
);
  localparam int EOP_CLKS = CLKS_PER_BIT * EOP_BITS;
  localparam int RW       = $clog2(EOP_CLKS + 2) + 1;

  logic          se0_now, se0_prev;
  logic [RW-1:0] se0_run;

  assign se0_now = oe && !dp && !dm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se0_prev <= 1'b0;
      se0_run  <= '0;
    end else begin
      se0_prev <= se0_now;
      if (se0_now) se0_run <= se0_run + RW'(1);
      else         se0_run <= '0;
    end
  end

  // R4
  no_se1_chk: assert property (@(posedge clk) disable iff (!rst_n) !(dp && dm));
  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !oe);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && !oe));
  // R3
  arm_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> ($past(dm) && !$past(dp)));
  // R8
  addr_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> se0_now);
  // R6
  eop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (se0_prev && !se0_now) |-> (se0_run == RW'(EOP_CLKS)));
  // R6
  eop_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (se0_prev && !se0_now) |-> (oe && dm && !dp));
  // R1
  fetch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> (busy && oe));
endmodule

bind lsx_pkt_tx lsx_tx_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT),
  .EOP_BITS    (EOP_BITS),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dp        (dp),
  .dm        (dm),
  .oe        (oe),
  .busy      (busy),
  .done      (done),
  .data_ready(data_ready),
  .dev_addr  (dev_addr)
);

// File: tb/sim_lsx_pkt_tx.sv
`timescale 1ns/1ps
module sim_lsx_pkt_tx;
  localparam int T = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_valid = 1'b0;
  logic       start_ready;
  logic [3:0] start_len = '0;
  logic       data_valid = 1'b1;
  logic       data_ready;
  logic [7:0] data_byte = '0;
  logic       hs_req = 1'b0;
  logic       hs_nak = 1'b0;
  logic       addr_wr = 1'b0;
  logic [6:0] addr_in = '0;
  logic [6:0] dev_addr;
  logic       dp, dm, oe, busy, done;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] pay [0:15];
  int         pidx = 0;
  logic [7:0] mdl_b [0:15];
  bit         exp_lvl [0:127];
  int         exp_n, exp_stuffs;
  bit         pend_v = 0;
  logic [6:0] pend_a = '0, cur_a = '0;

  always #10 clk = ~clk;

  lsx_pkt_tx u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_len(start_len), .data_valid(data_valid), .data_ready(data_ready),
    .data_byte(data_byte), .hs_req(hs_req), .hs_nak(hs_nak), .addr_wr(addr_wr),
    .addr_in(addr_in), .dev_addr(dev_addr), .dp(dp), .dm(dm), .oe(oe),
    .busy(busy), .done(done)
  );

  // payload source: byte taken on the edge after a cycle with data_ready high
  bit adv = 0;
  always @(negedge clk) begin
    if (!busy) begin
      pidx = 0;
      adv  = 0;
    end else if (adv) begin
      pidx = pidx + 1;
      adv  = 0;
    end
    data_byte = pay[pidx & 15];
    if (data_ready) adv = 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clampl(input int l);
    if (l < 2) return 2;
    if (l > 12) return 12;
    return l;
  endfunction

  task automatic build_model(input int nb);
    bit lv;
    int ones;
    lv = 1; ones = 0; exp_n = 0; exp_stuffs = 0;
    for (int i = 0; i < nb; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (mdl_b[i][b]) ones++;
        else begin lv = ~lv; ones = 0; end
        exp_lvl[exp_n] = lv; exp_n++;
        if (ones == 6) begin
          lv = ~lv; ones = 0;
          exp_lvl[exp_n] = lv; exp_n++; exp_stuffs++;
        end
      end
    end
  endtask

  task automatic write_addr(input logic [6:0] a);
    @(negedge clk);
    addr_wr = 1; addr_in = a;
    @(negedge clk);
    addr_wr = 0;
    pend_a = a; pend_v = 1;
  endtask

  task automatic run_pkt(input bit hs, input bit nak, input int len_req, input bit collide,
                         input logic [6:0] col_a, input int inject_at, input bit both);
    bit hse;
    int L, nt, rel, fetch, m_bad_a, m_bad_s, m_bad_w, m_bad_e, m_bad_b;
    logic [2:0] act3, exp3, a_w, e_w, a_e, e_e;
    bit eb, ed, sync_ok;
    logic [6:0] mid_addr, exp_mid;
    string wtag;
    hse = hs || both;
    L = hse ? 2 : clampl(len_req);
    mdl_b[0] = 8'h80;
    if (hse) mdl_b[1] = nak ? 8'h5A : 8'hD2;
    else for (int i = 1; i < L; i++) mdl_b[i] = pay[i-1];
    build_model(L);
    nt  = exp_n * T;
    rel = nt + 2*T + 2;
    fetch = 0; m_bad_a = -1; m_bad_s = -1; m_bad_w = -1; m_bad_e = -1; m_bad_b = -1;
    sync_ok = 1; mid_addr = '0; a_w = 0; e_w = 0; a_e = 0; e_e = 0;
    exp_mid = cur_a;
    @(negedge clk);
    chk(start_ready == !hs_req, "R9 start_ready idle", start_ready, 1);
    if (hse)  begin hs_req = 1; hs_nak = nak; end
    if (!hs || both) begin start_valid = 1; start_len = len_req[3:0]; end
    @(posedge clk);
    for (int m = 0; m <= rel + 6; m++) begin
      @(negedge clk);
      if (m == 0) begin hs_req = 0; start_valid = 0; end
      if (m == inject_at) begin
        chk(start_ready == 0, "R9 start_ready busy", start_ready, 0);
        hs_req = 1; start_valid = 1; start_len = 4'd5;
      end
      if (m == inject_at + 1) begin hs_req = 0; start_valid = 0; end
      if (collide && m == nt) begin addr_wr = 1; addr_in = col_a; end
      if (collide && m == nt + 1) begin addr_wr = 0; mid_addr = dev_addr; end
      if (data_ready && data_valid) fetch++;
      act3 = {dp, dm, oe};
      eb = (m <= rel - 1); ed = (m == rel);
      if (m == 0) exp3 = 3'b010;
      else if (m <= nt) exp3 = exp_lvl[(m-1)/T] ? 3'b011 : 3'b101;
      else if (m <= nt + 2*T) exp3 = 3'b001;
      else if (m == nt + 2*T + 1) exp3 = 3'b011;
      else exp3 = 3'b000;
      if (m == 0 && act3 != exp3) m_bad_a = m;
      else if (m >= 1 && m <= nt && act3 != exp3 && m_bad_w < 0) begin m_bad_w = m; a_w = act3; e_w = exp3; end
      else if (m > nt && act3 != exp3 && m_bad_e < 0) begin m_bad_e = m; a_e = act3; e_e = exp3; end
      if ((busy != eb || done != ed) && m_bad_b < 0) m_bad_b = m;
      for (int k = 0; k < 8; k++)
        if (m == 1 + k*T + T/2) if (dm != ((8'b0010_1010 >> k) & 1)) sync_ok = 0;
    end
    // address model
    if (!hse) begin
      if (pend_v) begin cur_a = pend_a; pend_v = 0; end
    end
    exp_mid = cur_a;
    if (collide) begin pend_a = col_a; pend_v = 1; end
    wtag = hse ? "R7 handshake waveform" : (exp_stuffs > 0 ? "R5 stuffed waveform" : "R4 nrzi waveform");
    chk(m_bad_a < 0, "R3 arm cycle", m_bad_a, -1);
    chk(sync_ok, "R2 sync pattern", sync_ok, 1);
    chk(m_bad_w < 0, wtag, a_w, e_w);
    chk(m_bad_e < 0, "R6 eop/release", a_e, e_e);
    chk(m_bad_b < 0, "R9 busy/done", m_bad_b, -1);
    chk(fetch == (hse ? 0 : L - 1), hse ? "R7 no fetch" : "R1 fetch count", fetch, hse ? 0 : L - 1);
    chk(dev_addr == cur_a, "R8 dev_addr", dev_addr, cur_a);
    if (collide) chk(mid_addr == exp_mid, "R8 collision commit", mid_addr, exp_mid);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd2718);
    for (int i = 0; i < 16; i++) pay[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({dp, dm, oe} == 3'b000, "R10 lines released", {dp, dm, oe}, 0);
    chk(!busy && !done, "R10 busy/done", {busy, done}, 0);
    chk(start_ready == 1, "R10 start_ready", start_ready, 1);
    chk(dev_addr == 0, "R10 dev_addr", dev_addr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    write_addr(7'h15);
    run_pkt(1, 0, 0, 0, 0, -5, 0);                 // R7 ACK, no commit
    run_pkt(1, 1, 0, 0, 0, -5, 0);                 // R7 NAK
    pay[0] = 8'hC3;
    run_pkt(0, 0, 2, 0, 0, -5, 0);                 // R8 commit 0x15
    run_pkt(0, 0, 0, 0, 0, -5, 0);                 // R1 clamp low
    for (int i = 0; i < 16; i++) pay[i] = 8'(i * 37 + 1);
    run_pkt(0, 0, 15, 0, 0, -5, 0);                // R1 clamp high
    pay[0] = 8'h4B; pay[1] = 8'hF0; pay[2] = 8'h03;
    run_pkt(0, 0, 4, 0, 0, -5, 0);                 // R5 run across bytes
    pay[0] = 8'hC3; pay[1] = 8'hFC;
    run_pkt(0, 0, 3, 0, 0, -5, 0);                 // R5 stuff before EOP
    for (int i = 0; i < 16; i++) pay[i] = 8'hFF;
    run_pkt(0, 0, 12, 0, 0, -5, 0);                // R5 long ones
    write_addr(7'h22);
    pay[0] = 8'h4B; pay[1] = 8'h00;
    run_pkt(0, 0, 3, 1, 7'h33, -5, 0);             // R8 collision
    run_pkt(0, 0, 2, 0, 0, 40, 0);                 // R8 second commit, R9 ignore busy requests
    run_pkt(0, 1, 5, 0, 0, -5, 1);                 // R7 priority over start
    for (int n = 0; n < 10; n++) begin
      for (int i = 0; i < 16; i++) pay[i] = 8'($urandom);
      if ($urandom % 3 == 0) run_pkt(1, 1'($urandom), 0, 0, 0, -5, 0);
      else run_pkt(0, 0, 2 + int'($urandom % 11), 0, 0, -5, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule